// File: doc/BRIEF.md
# Exception Entry and Vector Controller

This block is the part of a 32-bit soft processor that runs when an exception is taken. The pipeline presents a cause code and the program counter of the faulting or interrupted instruction. One clock later the block produces the handler address for the fetch unit. It also produces a write strobe for the return-address register that the cause class selects. In the same edge it updates the interrupt-enable register that it holds.

Causes fall into two classes. The normal class covers instruction bus error, data bus error, divide by zero, external interrupt and system call. These causes save the PC as the exception return address and back up the global enable into the exception shadow bit. The debug class covers breakpoint and watchpoint. These causes save the PC as the breakpoint return address and back up the global enable into the breakpoint shadow bit.

Each cause owns a 32-byte handler slot, which holds eight instructions, above a 256-byte-aligned base. Debug causes always use the debug base. A remap control moves the normal causes onto the debug base as well. Cause codes that do not name a handled exception raise an error pulse, and nothing else changes.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is high, and on the first edge after it is released, `pc_load_o`, `ra_we_o`, `cause_err_o` and `ie_o` are all zero.
- R2: A normal cause applied with `exc_valid_i` (codes 2 instruction bus error, 4 data bus error, 5 divide by zero, 6 interrupt, 7 system call) makes the outputs pulse for exactly one cycle, one clock later. In that cycle `pc_load_o`=1, `ra_we_o`=1, `ra_sel_o`=0 (exception return register) and `ra_data_o` equals the sampled `pc_i`.
- R3: A debug cause (code 1 breakpoint, code 3 watchpoint) gives the same one-cycle pulse with `ra_sel_o`=1 (breakpoint return register).
- R4: `ie_o` bit 0 is the global enable, bit 1 is the exception shadow and bit 2 is the breakpoint shadow. A normal cause copies bit 0 into bit 1 only when bit 0 was 1, leaves bit 2 unchanged, and always clears bit 0.
- R5: A debug cause copies bit 0 into bit 2 only when bit 0 was 1, leaves bit 1 unchanged, and always clears bit 0.
- R6: `pc_next_o` equals the selected base with its low 8 bits zeroed, ORed with the cause code shifted left by 5.
- R7: Debug causes always use `dbg_base_i`. Normal causes use `dbg_base_i` when `dbg_remap_i`=1 and `nrm_base_i` when it is 0.
- R8: A cause code of 0, or any code above 7, given with `exc_valid_i` pulses `cause_err_o` for one cycle. In that case `pc_load_o` and `ra_we_o` stay at 0 and the exception leaves `ie_o` unchanged.
- R9: With no exception taken, `ie_wr_en_i` loads `ie_wr_data_i` into `ie_o` on the next edge. A taken exception in the same cycle overrides the write.
- R10: The low 8 bits of both base inputs have no effect on `pc_next_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid_i | input | 1 | Exception request this cycle |
| exc_cause_i | input | CAUSE_W | Encoded cause |
| pc_i | input | XLEN | PC of the excepting instruction |
| nrm_base_i | input | XLEN | Normal handler base |
| dbg_base_i | input | XLEN | Debug handler base |
| dbg_remap_i | input | 1 | Send normal causes to the debug base |
| ie_wr_en_i | input | 1 | Write the enable register |
| ie_wr_data_i | input | 3 | New enable value {bshadow, eshadow, global} |
| pc_load_o | output | 1 | Redirect fetch to pc_next_o |
| pc_next_o | output | XLEN | Handler address |
| ra_we_o | output | 1 | Return-address write strobe |
| ra_sel_o | output | 1 | 0 exception return reg, 1 breakpoint return reg |
| ra_data_o | output | XLEN | Return address to write |
| ie_o | output | 3 | Enable register {bshadow, eshadow, global} |
| cause_err_o | output | 1 | Unrecognised cause pulse |

## Verification
The bench uses the default build, XLEN=32 and CAUSE_W=4. With four cause bits there are sixteen codes. The seven handled codes come alongside code 0 and eight codes above 7, so the error path is covered over a wide range. The sweep steps through every code, both states of the global enable, both prior shadow values and both remap settings. The base inputs carry non-zero low bytes, so a vector that leaked those bits would be detected.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    CODE_RESET = 3'd0,
    CODE_BREAK = 3'd1,
    CODE_IBUS  = 3'd2,
    CODE_WATCH = 3'd3,
    CODE_DBUS  = 3'd4,
    CODE_DIV0  = 3'd5,
    CODE_IRQ   = 3'd6,
    CODE_SCALL = 3'd7
  } exc_code_e;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_NORMAL = 2'd1,
    CLS_DEBUG  = 2'd2
  } exc_class_e;

  typedef struct packed {
    logic bshadow;
    logic eshadow;
    logic gie;
  } ie_bits_t;

  localparam int SLOT_LOG2 = 5;
  localparam int CODE_W    = 3;

endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
  import exc_entry_pkg::*;
#(
  parameter int CAUSE_W = 4
) (
  input  logic [CAUSE_W-1:0] cause_i,
  output exc_class_e         cls_o
);

  logic       hi_zero;
  exc_class_e base_cls;

  generate
    if (CAUSE_W > CODE_W) begin : g_wide
      assign hi_zero = (cause_i[CAUSE_W-1:CODE_W] == '0);
    end else begin : g_narrow
      assign hi_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    case (exc_code_e'(cause_i[CODE_W-1:0]))
      CODE_BREAK, CODE_WATCH: base_cls = CLS_DEBUG;
      CODE_IBUS, CODE_DBUS, CODE_DIV0, CODE_IRQ, CODE_SCALL: base_cls = CLS_NORMAL;
      default: base_cls = CLS_NONE;
    endcase
  end

  assign cls_o = hi_zero ? base_cls : CLS_NONE;

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   nrm_base_i,
  input  logic [XLEN-1:0]   dbg_base_i,
  input  logic              remap_i,
  input  logic              is_debug_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [XLEN-1:0]   vec_o
);

  localparam int ALIGN = SLOT_LOG2 + CODE_W;

  logic [XLEN-1:0] base;

  assign base  = (is_debug_i || remap_i) ? dbg_base_i : nrm_base_i;
  assign vec_o = {base[XLEN-1:ALIGN], code_i, {SLOT_LOG2{1'b0}}};

endmodule

// File: rtl/exc_ie_reg.sv
module exc_ie_reg
  import exc_entry_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     take_normal_i,
  input  logic     take_debug_i,
  input  logic     wr_en_i,
  input  ie_bits_t wr_data_i,
  output ie_bits_t ie_o
);

  ie_bits_t ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q <= '0;
    end else if (take_normal_i) begin
      if (ie_q.gie) ie_q.eshadow <= 1'b1;
      ie_q.gie <= 1'b0;
    end else if (take_debug_i) begin
      if (ie_q.gie) ie_q.bshadow <= 1'b1;
      ie_q.gie <= 1'b0;
    end else if (wr_en_i) begin
      ie_q <= wr_data_i;
    end
  end

  assign ie_o = ie_q;

  AST_GIE_OFF_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    (take_normal_i || take_debug_i) |=> !ie_q.gie); // R4

  AST_ESHADOW_KEPT_ON_DEBUG: assert property (@(posedge clk) disable iff (rst)
    take_debug_i |=> $stable(ie_q.eshadow)); // R5

  AST_BSHADOW_KEPT_ON_NORMAL: assert property (@(posedge clk) disable iff (rst)
    take_normal_i |=> $stable(ie_q.bshadow)); // R4

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exc_valid_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    nrm_base_i,
  input  logic [XLEN-1:0]    dbg_base_i,
  input  logic               dbg_remap_i,
  input  logic               ie_wr_en_i,
  input  logic [2:0]         ie_wr_data_i,
  output logic               pc_load_o,
  output logic [XLEN-1:0]    pc_next_o,
  output logic               ra_we_o,
  output logic               ra_sel_o,
  output logic [XLEN-1:0]    ra_data_o,
  output logic [2:0]         ie_o,
  output logic               cause_err_o
);

  exc_class_e      cls;
  logic            take_normal, take_debug, take_any, bad_cause;
  logic [XLEN-1:0] vec;
  ie_bits_t        ie_q;

  exc_cause_decode #(.CAUSE_W(CAUSE_W)) u_decode (
    .cause_i (exc_cause_i),
    .cls_o   (cls)
  );

  assign take_normal = exc_valid_i && (cls == CLS_NORMAL);
  assign take_debug  = exc_valid_i && (cls == CLS_DEBUG);
  assign take_any    = take_normal || take_debug;
  assign bad_cause   = exc_valid_i && (cls == CLS_NONE);

  exc_vector_gen #(.XLEN(XLEN)) u_vector (
    .nrm_base_i (nrm_base_i),
    .dbg_base_i (dbg_base_i),
    .remap_i    (dbg_remap_i),
    .is_debug_i (cls == CLS_DEBUG),
    .code_i     (exc_cause_i[CODE_W-1:0]),
    .vec_o      (vec)
  );

  exc_ie_reg u_ie (
    .clk           (clk),
    .rst           (rst),
    .take_normal_i (take_normal),
    .take_debug_i  (take_debug),
    .wr_en_i       (ie_wr_en_i),
    .wr_data_i     (ie_bits_t'(ie_wr_data_i)),
    .ie_o          (ie_q)
  );

  assign ie_o = ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_load_o   <= 1'b0;
      pc_next_o   <= '0;
      ra_we_o     <= 1'b0;
      ra_sel_o    <= 1'b0;
      ra_data_o   <= '0;
      cause_err_o <= 1'b0;
    end else begin
      pc_load_o   <= take_any;
      ra_we_o     <= take_any;
      cause_err_o <= bad_cause;
      if (take_any) begin
        pc_next_o <= vec;
        ra_sel_o  <= take_debug;
        ra_data_o <= pc_i;
      end
    end
  end

  AST_LOAD_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    pc_load_o |-> $past(exc_valid_i)); // R2

  AST_RA_IS_PC: assert property (@(posedge clk) disable iff (rst)
    ra_we_o |-> (ra_data_o == $past(pc_i))); // R2

  AST_VEC_SLOT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc_load_o |-> (pc_next_o[SLOT_LOG2-1:0] == '0)); // R6

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(cause_err_o && (pc_load_o || ra_we_o))); // R8

  AST_ERR_IE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cause_err_o && !$past(ie_wr_en_i)) |-> (ie_o == $past(ie_o))); // R8

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (pc_load_o && !$past(exc_valid_i, 1)) |-> 1'b0); // R3

endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;

  localparam int XLEN    = 32;
  localparam int CAUSE_W = 4;

  logic               clk = 1'b0;
  logic               rst;
  logic               exc_valid_i;
  logic [CAUSE_W-1:0] exc_cause_i;
  logic [XLEN-1:0]    pc_i, nrm_base_i, dbg_base_i;
  logic               dbg_remap_i, ie_wr_en_i;
  logic [2:0]         ie_wr_data_i;
  logic               pc_load_o, ra_we_o, ra_sel_o, cause_err_o;
  logic [XLEN-1:0]    pc_next_o, ra_data_o;
  logic [2:0]         ie_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  exc_entry_ctrl #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) i_exc_entry_ctrl (
    .clk(clk), .rst(rst), .exc_valid_i(exc_valid_i), .exc_cause_i(exc_cause_i),
    .pc_i(pc_i), .nrm_base_i(nrm_base_i), .dbg_base_i(dbg_base_i),
    .dbg_remap_i(dbg_remap_i), .ie_wr_en_i(ie_wr_en_i), .ie_wr_data_i(ie_wr_data_i),
    .pc_load_o(pc_load_o), .pc_next_o(pc_next_o), .ra_we_o(ra_we_o),
    .ra_sel_o(ra_sel_o), .ra_data_o(ra_data_o), .ie_o(ie_o), .cause_err_o(cause_err_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; exc_valid_i = 0; exc_cause_i = '0; pc_i = '0;
    nrm_base_i = 32'h1234_56FF; dbg_base_i = 32'hABCD_E0A5;
    dbg_remap_i = 0; ie_wr_en_i = 0; ie_wr_data_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pc_load", pc_load_o, 0);
    chk("R1 ra_we", ra_we_o, 0);
    chk("R1 err", cause_err_o, 0);
    chk("R1 ie", ie_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {pc_load_o, ra_we_o, cause_err_o, ie_o}, 0);

    // R9: plain write of the enable register
    ie_wr_en_i = 1; ie_wr_data_i = 3'b101;
    @(negedge clk);
    ie_wr_en_i = 0;
    chk("R9 ie write", ie_o, 3'b101);

    for (int c = 0; c < 16; c++) begin
      for (int g = 0; g < 2; g++) begin
        for (int s = 0; s < 2; s++) begin
          for (int m = 0; m < 2; m++) begin
            logic            valid_c, dbg_c;
            logic [2:0]      prior, exp_ie;
            logic [XLEN-1:0] base, exp_pc, pcv;
            prior = {s[0], s[0], g[0]};
            ie_wr_en_i = 1; ie_wr_data_i = prior;
            @(negedge clk);
            ie_wr_en_i = 0;
            pcv = 32'h8000_0000 + (c * 256 + g * 64 + s * 16 + m * 4);
            exc_valid_i = 1; exc_cause_i = c[CAUSE_W-1:0]; pc_i = pcv; dbg_remap_i = m[0];
            @(negedge clk);
            exc_valid_i = 0;
            valid_c = (c >= 1) && (c <= 7);
            dbg_c   = (c == 1) || (c == 3);
            base    = (dbg_c || m[0]) ? dbg_base_i : nrm_base_i;
            exp_pc  = {base[31:8], 8'h00} | (c << 5);
            exp_ie  = prior;
            if (valid_c) begin
              if (g[0]) begin
                if (dbg_c) exp_ie[2] = 1'b1; else exp_ie[1] = 1'b1;
              end
              exp_ie[0] = 1'b0;
            end
            if (valid_c) begin
              chk(dbg_c ? "R3 pc_load" : "R2 pc_load", pc_load_o, 1);
              chk(dbg_c ? "R3 ra_we" : "R2 ra_we", ra_we_o, 1);
              chk(dbg_c ? "R3 ra_sel" : "R2 ra_sel", ra_sel_o, dbg_c);
              chk("R2 ra_data", ra_data_o, pcv);
              chk(dbg_c ? "R7 debug base" : "R7 remap", pc_next_o, exp_pc);
              chk("R6 R10 vector", pc_next_o, exp_pc);
              chk(dbg_c ? "R5 ie" : "R4 ie", ie_o, exp_ie);
              chk("R8 no err", cause_err_o, 0);
            end else begin
              chk("R8 err", cause_err_o, 1);
              chk("R8 no load", {pc_load_o, ra_we_o}, 0);
              chk("R8 ie kept", ie_o, prior);
            end
            @(negedge clk);
            chk("R2 single pulse", {pc_load_o, ra_we_o, cause_err_o}, 0);
          end
        end
      end
    end

    // R9: exception overrides a write in the same cycle
    ie_wr_en_i = 1; ie_wr_data_i = 3'b001;
    @(negedge clk);
    ie_wr_data_i = 3'b111; exc_valid_i = 1; exc_cause_i = 4'd6; dbg_remap_i = 0;
    @(negedge clk);
    ie_wr_en_i = 0; exc_valid_i = 0;
    chk("R9 exception wins", ie_o, 3'b010);
    chk("R9 load", pc_load_o, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule